// File: doc/BRIEF.md
# Converter Start-up and Calibration Sequencer

This block runs the start-up sequence for a stereo converter frame engine. It watches a functional reset request, a power-down request and a one-cycle frame strobe. From these it drives the controls that the rest of the engine obeys:

- a calibration-busy flag;
- a mute request for the playback path;
- a gate that forces captured samples to zero;
- a capture-valid flag;
- a synchronous clear for the control registers;
- an enable and a force-low control for the general-purpose output pins.

After a reset request that has been held long enough, or after power-down ends, the block counts a fixed number of frames of offset calibration. It then counts a parameterised number of frames of filter latency. Only after both windows does it declare capture data valid. If the reset request is held for too short a time, the block enters a fault hold and waits for a proper reset. A power-down first drives the pins low for a short interval and then releases them to high impedance. A new reset or power-down at any point aborts the counting, and the whole sequence starts again.

Top module: `startup_sequencer`

## Requirements
- R1: While `reset_req_n` is sampled low and `pwr_down_n` is high, the outputs in the following cycle are: `ctrl_clear`=1, `pin_oe`=1, `pin_drive_low`=1, `dac_mute`=1, `adc_zero`=1, `adc_valid`=0 and `cal_busy`=0.
- R2: Suppose `reset_req_n` has been sampled low on at least SETTLE_CYC consecutive clock edges. Then the first edge that samples it high starts calibration, and `cal_busy` reads 1 after that edge.
- R3: Suppose `reset_req_n` goes high after fewer than SETTLE_CYC low samples. Then the block holds with `cal_busy`=0, `dac_mute`=1, `adc_zero`=1, `adc_valid`=0, `ctrl_clear`=0, and pins enabled and driven low. Frame strobes do not change this. Only a new reset request or a power-down ends the hold.
- R4: Calibration lasts exactly CAL_FRAMES (default 194) sampled frame strobes. `cal_busy` falls at the edge that samples the last of them.
- R5: During calibration, `dac_mute`=1, `adc_zero`=1 and `adc_valid`=0, while the pins are enabled and not forced low.
- R6: After calibration, LAT_FRAMES further frame strobes pass with `dac_mute`=0, `adc_zero`=0 and `adc_valid`=0. `adc_valid` rises only at an edge that samples a frame strobe: the one that completes the latency window.
- R7: A low sample of `pwr_down_n` takes priority over the reset request. For PD_LOW_CYC cycles the outputs are `pin_oe`=1 and `pin_drive_low`=1. After that, `pin_oe`=0. Throughout, the block is muted, zeroed and not valid.
- R8: When `pwr_down_n` is sampled high again, calibration starts after that edge if `reset_req_n` is high. If `reset_req_n` is low, the block enters the R1 state instead.
- R9: A reset request or power-down during calibration, the latency window or normal running aborts the count. The next sequence again takes the full CAL_FRAMES plus LAT_FRAMES strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| reset_req_n | input | 1 | Functional reset request, active low, synchronous |
| pwr_down_n | input | 1 | Power-down request, active low, synchronous |
| frame_tick | input | 1 | One-cycle strobe at each frame start |
| cal_busy | output | 1 | Offset calibration in progress |
| dac_mute | output | 1 | Mute request for the playback path |
| adc_zero | output | 1 | Force captured samples to zero |
| adc_valid | output | 1 | Capture data valid |
| ctrl_clear | output | 1 | Synchronous clear for control registers |
| pin_oe | output | 1 | Output enable for the general-purpose output pins |
| pin_drive_low | output | 1 | Force enabled pins to logic low |

## Verification
Reset requests are applied in two lengths: one just above the settle count and one well below it. This separates the calibration start from the fault hold. Long runs of frame strobes, spaced every fourth cycle, are counted through calibration and latency. These runs show that the windows are counted in strobes rather than cycles, and that they end on the exact strobe. Aborts are tried in the middle of calibration and again after the sequence has finished. Power-down is applied during normal running and while a reset is held. This separates the drive-low-then-float order from the two ways the block can leave power-down.

// File: rtl/startup_pkg.sv
package startup_pkg;
  typedef enum logic [2:0] {
    ST_RESET,
    ST_HOLD,
    ST_PD_DRIVE,
    ST_PD_FLOAT,
    ST_CAL,
    ST_LATENCY,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_low,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!hold_low)          cnt_d = '0;
    else if (cnt_q == LIMIT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign settled = (cnt_q == LIMIT);

  assert_settle_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> $past(hold_low));
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int MAX_COUNT = 194
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic [$clog2(MAX_COUNT+1)-1:0] cnt
);
  localparam int CW = $clog2(MAX_COUNT + 1);

  logic [CW-1:0] cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
    else          cnt_d = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assert_count_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && cnt != $past(cnt)) |-> $past(inc));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import startup_pkg::*;
#(
  parameter int CAL_FRAMES = 194,
  parameter int LAT_FRAMES = 20,
  parameter int PD_LOW_CYC = 8,
  parameter int FCW        = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rs_low,
  input  logic           pd_act,
  input  logic           tick,
  input  logic           settled,
  input  logic [FCW-1:0] fcnt,
  output seq_state_e     state,
  output logic           fc_clr,
  output logic           fc_inc
);
  localparam int PW = $clog2(PD_LOW_CYC + 1);
  localparam logic [PW-1:0]  PD_LAST  = PW'(PD_LOW_CYC - 1);
  localparam logic [FCW-1:0] CAL_LAST = FCW'(CAL_FRAMES - 1);
  localparam logic [FCW-1:0] LAT_LAST = FCW'(LAT_FRAMES - 1);

  seq_state_e    nxt;
  logic [PW-1:0] pd_cnt, pd_cnt_d;
  logic          counting;

  assign counting = (state == ST_CAL) || (state == ST_LATENCY);

  always_comb begin
    nxt      = state;
    pd_cnt_d = pd_cnt;
    if (pd_act) begin
      if (state == ST_PD_DRIVE) begin
        if (pd_cnt == PD_LAST) nxt = ST_PD_FLOAT;
        else                   pd_cnt_d = pd_cnt + 1'b1;
      end else if (state != ST_PD_FLOAT) begin
        nxt      = ST_PD_DRIVE;
        pd_cnt_d = '0;
      end
    end else if (rs_low) begin
      nxt = ST_RESET;
    end else begin
      case (state)
        ST_RESET:                 nxt = settled ? ST_CAL : ST_HOLD;
        ST_PD_DRIVE, ST_PD_FLOAT: nxt = ST_CAL;
        ST_CAL:     if (tick && fcnt == CAL_LAST) nxt = ST_LATENCY;
        ST_LATENCY: if (tick && fcnt == LAT_LAST) nxt = ST_RUN;
        default:    nxt = state;
      endcase
    end
  end

  assign fc_inc = tick && counting;
  assign fc_clr = (nxt != state) || !counting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_RESET;
      pd_cnt <= '0;
    end else begin
      state  <= nxt;
      pd_cnt <= pd_cnt_d;
    end
  end

  assert_float_after_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PD_FLOAT) |-> ($past(state) == ST_PD_DRIVE || $past(state) == ST_PD_FLOAT));
  assert_cal_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_CAL) |-> $past(!rs_low && !pd_act));
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_pkg::*;
#(
  parameter int SETTLE_CYC = 2_500_000,
  parameter int CAL_FRAMES = 194,
  parameter int LAT_FRAMES = 20,
  parameter int PD_LOW_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_req_n,
  input  logic pwr_down_n,
  input  logic frame_tick,
  output logic cal_busy,
  output logic dac_mute,
  output logic adc_zero,
  output logic adc_valid,
  output logic ctrl_clear,
  output logic pin_oe,
  output logic pin_drive_low
);
  localparam int MAXF = (CAL_FRAMES > LAT_FRAMES) ? CAL_FRAMES : LAT_FRAMES;
  localparam int FCW  = $clog2(MAXF + 1);

  seq_state_e     state;
  logic           settled, fc_clr, fc_inc;
  logic [FCW-1:0] fcnt;

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .hold_low(!reset_req_n), .settled(settled));

  frame_counter #(.MAX_COUNT(MAXF)) u_frames (
    .clk(clk), .rst_n(rst_n), .clr(fc_clr), .inc(fc_inc), .cnt(fcnt));

  seq_fsm #(
    .CAL_FRAMES(CAL_FRAMES), .LAT_FRAMES(LAT_FRAMES),
    .PD_LOW_CYC(PD_LOW_CYC), .FCW(FCW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .rs_low(!reset_req_n), .pd_act(!pwr_down_n),
    .tick(frame_tick), .settled(settled), .fcnt(fcnt),
    .state(state), .fc_clr(fc_clr), .fc_inc(fc_inc));

  always_comb begin
    cal_busy      = (state == ST_CAL);
    adc_valid     = (state == ST_RUN);
    dac_mute      = !((state == ST_RUN) || (state == ST_LATENCY));
    adc_zero      = dac_mute;
    ctrl_clear    = (state == ST_RESET);
    pin_oe        = (state != ST_PD_FLOAT);
    pin_drive_low = (state == ST_RESET) || (state == ST_HOLD) || (state == ST_PD_DRIVE);
  end

  assert_busy_muted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_busy |-> (dac_mute && adc_zero && !adc_valid && pin_oe && !pin_drive_low));
  assert_valid_on_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_valid) |-> $past(frame_tick));
  assert_clear_drives_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clear |-> (pin_oe && pin_drive_low && dac_mute && !adc_valid));
  assert_pd_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!pwr_down_n) |-> (!adc_valid && !cal_busy && !ctrl_clear));
endmodule

// File: tb/tb_startup_sequencer.sv
module tb_startup_sequencer;
  localparam int SETTLE = 40;
  localparam int CALF   = 194;
  localparam int LATF   = 6;
  localparam int PDL    = 5;

  logic clk = 1'b0;
  logic rst_n, reset_req_n, pwr_down_n, frame_tick;
  logic cal_busy, dac_mute, adc_zero, adc_valid, ctrl_clear, pin_oe, pin_drive_low;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  startup_sequencer #(
    .SETTLE_CYC(SETTLE), .CAL_FRAMES(CALF), .LAT_FRAMES(LATF), .PD_LOW_CYC(PDL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .reset_req_n(reset_req_n), .pwr_down_n(pwr_down_n),
    .frame_tick(frame_tick), .cal_busy(cal_busy), .dac_mute(dac_mute),
    .adc_zero(adc_zero), .adc_valid(adc_valid), .ctrl_clear(ctrl_clear),
    .pin_oe(pin_oe), .pin_drive_low(pin_drive_low));

  // behavioural reference: mode 0 reset, 1 hold, 2 pd drive, 3 pd float, 4 sequencing, 5 running
  int m_mode = 0, m_low = 0, m_pd = 0, m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_low = 0; m_pd = 0; m_left = 0;
    end else begin
      if (!pwr_down_n) begin
        if (m_mode == 2) begin
          if (m_pd == PDL - 1) m_mode = 3; else m_pd++;
        end else if (m_mode != 3) begin
          m_mode = 2; m_pd = 0;
        end
      end else if (!reset_req_n) m_mode = 0;
      else if (m_mode == 0) begin
        if (m_low >= SETTLE) begin m_mode = 4; m_left = CALF + LATF; end
        else m_mode = 1;
      end else if (m_mode == 2 || m_mode == 3) begin
        m_mode = 4; m_left = CALF + LATF;
      end else if (m_mode == 4 && frame_tick) begin
        m_left--;
        if (m_left == 0) m_mode = 5;
      end
      if (reset_req_n) m_low = 0;
      else if (m_low < SETTLE) m_low++;
    end
  end

  function automatic logic [6:0] expected();
    logic busy, live;
    busy = (m_mode == 4) && (m_left > LATF);
    live = (m_mode == 5) || (m_mode == 4 && m_left <= LATF);
    return {busy, !live, !live, m_mode == 5, m_mode == 0, m_mode != 3,
            m_mode == 0 || m_mode == 1 || m_mode == 2};
  endfunction

  function automatic string req_of();
    case (m_mode)
      0: return "R1";
      1: return "R3";
      2, 3: return "R7";
      4: return (m_left > LATF) ? "R5" : "R6";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic [6:0] act;
      act = {cal_busy, dac_mute, adc_zero, adc_valid, ctrl_clear, pin_oe, pin_drive_low};
      check(act == expected(), req_of(), act, expected());
    end
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin frame_tick = 1'b0; @(negedge clk); end
  endtask

  // drive strobes every fourth cycle until a flag changes; count sampled strobes
  task automatic count_until_busy_falls(output int n);
    n = 0;
    for (int k = 0; k < 4 * (CALF + 10); k++) begin
      frame_tick = (k % 4 == 3);
      @(negedge clk);
      if (frame_tick) n++;
      if (!cal_busy) break;
    end
    frame_tick = 1'b0;
  endtask

  task automatic count_until_valid(output int n);
    n = 0;
    for (int k = 0; k < 4 * (LATF + 10); k++) begin
      frame_tick = (k % 4 == 3);
      @(negedge clk);
      if (frame_tick) n++;
      if (adc_valid) break;
    end
    frame_tick = 1'b0;
  endtask

  task automatic long_reset();
    reset_req_n = 1'b0;
    idle(SETTLE + 3);
    check(ctrl_clear && pin_oe && pin_drive_low && dac_mute && !adc_valid, "R1",
          {ctrl_clear, pin_oe, pin_drive_low, dac_mute, adc_valid}, 5'b11110);
    reset_req_n = 1'b1;
    idle(1);
    check(cal_busy, "R2", cal_busy, 1);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; reset_req_n = 1'b0; pwr_down_n = 1'b1; frame_tick = 1'b0;
    @(negedge clk); @(negedge clk);
    check(ctrl_clear && !adc_valid && !cal_busy, "R1", {ctrl_clear, adc_valid, cal_busy}, 3'b100);
    rst_n = 1'b1;

    // full start-up sequence
    long_reset();
    count_until_busy_falls(n);
    check(n == CALF, "R4", n, CALF);
    check(!dac_mute && !adc_zero && !adc_valid, "R6", {dac_mute, adc_zero, adc_valid}, 0);
    count_until_valid(n);
    check(n == LATF && adc_valid, "R6", n, LATF);

    // short reset leads to the fault hold
    reset_req_n = 1'b0; idle(10);
    reset_req_n = 1'b1;
    for (int k = 0; k < 40; k++) begin frame_tick = (k % 4 == 3); @(negedge clk); end
    frame_tick = 1'b0;
    check(!cal_busy && dac_mute && !adc_valid && pin_drive_low && !ctrl_clear, "R3",
          {cal_busy, dac_mute, adc_valid, pin_drive_low, ctrl_clear}, 5'b01010);

    // abort in the middle of calibration
    long_reset();
    for (int k = 0; k < 200; k++) begin frame_tick = (k % 4 == 3); @(negedge clk); end
    frame_tick = 1'b0;
    long_reset();
    count_until_busy_falls(n);
    check(n == CALF, "R9", n, CALF);
    count_until_valid(n);
    check(n == LATF, "R9", n, LATF);

    // power-down while running: drive low, then float, then restart
    pwr_down_n = 1'b0;
    idle(1);
    check(pin_oe && pin_drive_low && !adc_valid, "R7", {pin_oe, pin_drive_low, adc_valid}, 3'b110);
    idle(PDL);
    check(!pin_oe && !adc_valid, "R7", {pin_oe, adc_valid}, 0);
    pwr_down_n = 1'b1;
    idle(1);
    check(cal_busy, "R8", cal_busy, 1);
    count_until_busy_falls(n);
    check(n == CALF, "R9", n, CALF);

    // power-down released while reset is held
    pwr_down_n = 1'b0; reset_req_n = 1'b0;
    idle(PDL + 3);
    check(!ctrl_clear && !pin_oe, "R7", {ctrl_clear, pin_oe}, 0);
    pwr_down_n = 1'b1;
    idle(1);
    check(ctrl_clear && !cal_busy, "R8", {ctrl_clear, cal_busy}, 2'b10);
    idle(SETTLE);
    reset_req_n = 1'b1;
    idle(1);
    check(cal_busy, "R2", cal_busy, 1);
    idle(4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule